// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM

This block drives several pulse-width-modulated outputs from one free-running up-counter. The highest match slot holds the period: when the counter would reach it, the counter returns to zero, so every output shares the same cycle. Each of the remaining slots holds a pulse value. An enabled output stays low while the counter is below its pulse value and goes high from the compare point until the period restart.

Software programs the period and pulse values through a single write port that selects one match slot per write. Pulse values may be rewritten while the outputs run. A separate request port turns a PWM channel on or off and selects whether it raises an interrupt. A request that names the period slot is refused and reported on an error strobe. Each channel has a sticky compare flag, which is cleared by writing a one. The interrupt line is the OR of the flags whose interrupt is enabled.

Top module: `pwm_period_bank`

## Requirements
- R1: After reset the counter, the period, all pulse values, the enables, the interrupt enables, the flags, `err_o`, `irq_o` and all `pwm_o` bits are zero.
- R2: While `run` is high the counter rises by one per clock. While `run` is low it holds its value.
- R3: Slot index NCH (3 by default) holds the period P. The counter counts 0 to P-1 and then returns to 0. With P equal to 0 or 1 it stays at 0. If the count is already at or above P-1, the next advance returns it to 0.
- R4: `pwm_o[i]` is 1 exactly when channel i is enabled and the counter is greater than or equal to pulse value i. A disabled channel outputs 0.
- R5: An enabled channel with pulse value 0 outputs a constant 1. An enabled channel with a pulse value at or above P outputs a constant 0.
- R6: Writing a pulse value while the counter runs changes the compare from the cycle after the write. No shadow copy waits for the period end.
- R7: A mode request with `mode_ch` equal to or above NCH (the period slot, code 3) changes no enable. `err_o` is 1 for exactly the cycle after such a request, and is 0 otherwise.
- R8: `flag_o[i]` is set in the cycle after a clock in which `run` is high, channel i is enabled and the counter equals pulse value i. It stays set until a clock in which `flag_clr[i]` is 1 and no new set occurs; a set in the same clock wins over the clear.
- R9: `irq_o` is 1 exactly when some `flag_o[i]` is set and that channel's interrupt enable (`mode_irq` at its last accepted request) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter advance enable |
| cfg_we | input | 1 | Write strobe for a match slot |
| cfg_sel | input | SEL_W | Slot index: 0..NCH-1 pulse values, NCH period |
| cfg_data | input | CNT_W | Value written to the selected slot |
| mode_req | input | 1 | Channel mode request strobe |
| mode_ch | input | SEL_W | Channel addressed by the request |
| mode_on | input | 1 | 1 enables PWM on the channel, 0 disables it |
| mode_irq | input | 1 | Interrupt enable stored with the request |
| flag_clr | input | NCH | Write-one-to-clear for the compare flags |
| count_o | output | CNT_W | Current counter value |
| pwm_o | output | NCH | PWM outputs |
| flag_o | output | NCH | Sticky compare flags |
| irq_o | output | 1 | Interrupt request |
| err_o | output | 1 | Rejected-request strobe |

## Verification
The bench sweeps a set of small periods, including 0, 1 and 2, and for each one it sweeps the pulse value from 0 to one past the period. This exposes an off-by-one in the wrap, which would stretch or shorten the cycle, and a wrong comparison at the edges, which would make a 0 pulse drop low for one count or let an out-of-range pulse produce a sliver of high output. It issues requests on the reserved slot, where a faulty decoder would enable a fourth output or stay silent on `err_o`. It rewrites pulse values mid-cycle, which catches a design that delays the update or glitches. It also clears flags in the same cycle as a new compare, where a design with the wrong priority would lose the event.

// File: rtl/pwm_period_bank.sv
module pwm_period_bank #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3,
  localparam int SEL_W = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CNT_W-1:0] cfg_data,
  input  logic             mode_req,
  input  logic [SEL_W-1:0] mode_ch,
  input  logic             mode_on,
  input  logic             mode_irq,
  input  logic [NCH-1:0]   flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic [NCH-1:0]   pwm_o,
  output logic [NCH-1:0]   flag_o,
  output logic             irq_o,
  output logic             err_o
);
  localparam logic [SEL_W-1:0] PERIOD_SLOT = SEL_W'(NCH);

  logic [CNT_W-1:0] cnt_q, period_q;
  logic [NCH-1:0]   en_q, ie_q, flag_q;
  logic             err_q;

  logic [CNT_W:0] cnt_inc;
  logic           wrap;
  logic           req_bad;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap    = cnt_inc >= {1'b0, period_q};
  assign req_bad = mode_req && (mode_ch >= PERIOD_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      period_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (run) cnt_q <= wrap ? '0 : cnt_inc[CNT_W-1:0];
      if (cfg_we && cfg_sel == PERIOD_SLOT) period_q <= cfg_data;
      err_q <= req_bad;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] pulse_q;
    logic             hit;

    assign hit = run && en_q[i] && (cnt_q == pulse_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pulse_q   <= '0;
        en_q[i]   <= 1'b0;
        ie_q[i]   <= 1'b0;
        flag_q[i] <= 1'b0;
      end else begin
        if (cfg_we && cfg_sel == SEL_W'(i)) pulse_q <= cfg_data;
        if (mode_req && mode_ch == SEL_W'(i)) begin
          en_q[i] <= mode_on;
          ie_q[i] <= mode_irq;
        end
        flag_q[i] <= hit || (flag_q[i] && !flag_clr[i]);
      end
    end

    assign pwm_o[i] = en_q[i] && (cnt_q >= pulse_q);

    assert_zero_pulse_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && pulse_q == '0) |-> pwm_o[i]);

    assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(run && en_q[i] && cnt_q == pulse_q));
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
  assign irq_o   = |(flag_q & ie_q);
  assign err_o   = err_q;

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  assert_period_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && period_q != '0 && cnt_q == period_q - 1'b1) |=> cnt_q == '0);

  assert_reserved_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && mode_ch == PERIOD_SLOT) |=> (err_o && $stable(en_q)));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(mode_req));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));
endmodule

// File: tb/pwm_period_bank_bench.sv
`timescale 1ns/1ps
module pwm_period_bank_bench;
  localparam int W = 8;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [W-1:0] cfg_data = '0;
  logic mode_req = 1'b0;
  logic [1:0] mode_ch = '0;
  logic mode_on = 1'b0;
  logic mode_irq = 1'b0;
  logic [N-1:0] flag_clr = '0;
  logic [W-1:0] count_o;
  logic [N-1:0] pwm_o, flag_o;
  logic irq_o, err_o;

  always #2.5 clk = ~clk;

  pwm_period_bank #(.CNT_W(W), .NCH(N)) u_pwm_period_bank (
    .clk, .rst_n, .run, .cfg_we, .cfg_sel, .cfg_data, .mode_req, .mode_ch,
    .mode_on, .mode_irq, .flag_clr, .count_o, .pwm_o, .flag_o, .irq_o, .err_o);

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  bit upd_phase = 1'b0;

  int m_cnt, m_per;
  int m_pulse [N];
  bit m_en [N];
  bit m_ie [N];
  bit m_flag [N];
  bit m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_per <= 0; m_err <= 0;
      for (int i = 0; i < N; i++) begin
        m_pulse[i] <= 0; m_en[i] <= 0; m_ie[i] <= 0; m_flag[i] <= 0;
      end
    end else begin
      if (run) m_cnt <= (m_cnt + 1 >= m_per) ? 0 : m_cnt + 1;
      if (cfg_we) begin
        if (cfg_sel == 2'd3) m_per <= int'(cfg_data);
        else m_pulse[cfg_sel] <= int'(cfg_data);
      end
      m_err <= mode_req && mode_ch == 2'd3;
      if (mode_req && mode_ch != 2'd3) begin
        m_en[mode_ch] <= mode_on; m_ie[mode_ch] <= mode_irq;
      end
      for (int i = 0; i < N; i++)
        m_flag[i] <= (run && m_en[i] && m_cnt == m_pulse[i]) || (m_flag[i] && !flag_clr[i]);
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit irq_e;
    chk(int'(count_o) == m_cnt, (m_cnt == 0) ? "R3" : "R2", "count", int'(count_o), m_cnt);
    irq_e = 1'b0;
    for (int i = 0; i < N; i++) begin
      bit e;
      string t;
      e = m_en[i] && (m_cnt >= m_pulse[i]);
      t = upd_phase ? "R6" : ((m_pulse[i] == 0 || m_pulse[i] >= m_per) ? "R5" : "R4");
      chk(pwm_o[i] == e, t, $sformatf("pwm[%0d]", i), int'(pwm_o[i]), int'(e));
      chk(flag_o[i] == m_flag[i], "R8", $sformatf("flag[%0d]", i), int'(flag_o[i]), int'(m_flag[i]));
      irq_e |= m_flag[i] && m_ie[i];
    end
    chk(irq_o == irq_e, "R9", "irq", int'(irq_o), int'(irq_e));
    chk(err_o == m_err, "R7", "err", int'(err_o), int'(m_err));
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(int sel, int val);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = W'(val);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic req(int ch, bit on, bit irq);
    mode_req = 1'b1; mode_ch = 2'(ch); mode_on = on; mode_irq = irq;
    step();
    mode_req = 1'b0;
  endtask

  initial begin
    int periods [6] = '{0, 1, 2, 3, 5, 7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(count_o == '0, "R1", "count", int'(count_o), 0);
    chk(pwm_o == '0, "R1", "pwm", int'(pwm_o), 0);
    chk(flag_o == '0 && irq_o == 1'b0, "R1", "flags", int'(flag_o), 0);
    chk(err_o == 1'b0, "R1", "err", int'(err_o), 0);
    // R4: disabled channels stay low while running
    run = 1'b1;
    repeat (4) step();
    run = 1'b0;
    foreach (periods[k]) begin
      int per;
      per = periods[k];
      wr(3, per);
      for (int p = 0; p <= per + 1; p++) begin
        wr(0, p);
        wr(1, (per > p) ? per - p : 0);
        wr(2, p + 1);
        req(0, 1'b1, 1'b1);
        req(1, (p % 2) == 0, 1'b0);
        req(2, 1'b1, 1'b1);
        req(3, 1'b1, 1'b1); // R7: reserved slot refused
        run = 1'b1;
        for (int c = 0; c < 2 * per + 4; c++) begin
          flag_clr = (c % 3 == 2) ? 3'b111 : 3'b000;
          step();
        end
        flag_clr = '0;
        upd_phase = 1'b1; // R6: live rewrite of a pulse value
        wr(0, (p + 1) % (per + 1));
        for (int c = 0; c < per + 2; c++) step();
        upd_phase = 1'b0;
        run = 1'b0; // R2: hold
        repeat (2) step();
      end
    end
    // R3: shrink period below current count while running
    wr(3, 9);
    run = 1'b1;
    repeat (7) step();
    wr(3, 3);
    repeat (6) step();
    // R7: refused request leaves channels intact; R8 clear of idle flags
    req(3, 1'b0, 1'b0);
    flag_clr = '1;
    step();
    flag_clr = '0;
    repeat (4) step();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule